// File: doc/BRIEF.md
# Read Burst Output Sequencer for a Single-Data-Rate DRAM Model

This block reproduces the read-data timing of a single-data-rate synchronous DRAM die. Each clock it takes one decoded command (read, write, burst stop, bank close, mode load or idle) together with a chip-select, a bank number, a column and a per-cycle data-mask bit. It then reports, cycle by cycle, whether read data would be driven and which column that word comes from. It holds no storage array. Its purpose is to supply the exact cycle placement of read words to a memory model or a controller test environment.

A read starts a burst of 1, 2, 4 or 8 words. The words step upward through the aligned block that holds the start column and wrap at its end. The first word appears a fixed latency of 2 or 3 cycles after the command. A later read, a burst stop or a close of the reading bank truncates a running burst at that same latency offset. A write cuts off all pending read output at once and flags a bus conflict if unmasked read data was still due. A data-mask bit suppresses the read word two cycles later.

Top module: `rdburst_seq`

## Requirements
- R1: A synchronous reset clears `dout_valid` and `bus_conflict` to 0 and selects burst length 4 and read latency 3.
- R2: A read (`cmd`=1) sampled at edge t puts its first word on the output registered at edge t+L, where L is 2 when the latency code is 0 and 3 when it is 1.
- R3: A burst of length B gives one word per edge on consecutive edges: word i has column (start & ~(B-1)) | ((start+i) & (B-1)).
- R4: A mode load (`cmd`=5) sets the length code `mode_bl` (0,1,2,3 give lengths 1,2,4,8) and the latency code `mode_cl`. It takes effect only when no read word is due at its own edge or later; otherwise it is ignored.
- R5: A read at edge t replaces every word of an earlier burst that would land at edge t+L or later.
- R6: A burst stop (`cmd`=3), or a bank close (`cmd`=4) naming the bank of the running burst or with `pre_all` set, removes every read word that would land at edge t+L or later.
- R7: A bank close that names another bank with `pre_all` low leaves the running burst unchanged.
- R8: `dqm` high at edge t suppresses the word due at edge t+2. That word still uses its slot in the burst.
- R9: With `cs_n` high, the command at that edge has no effect.
- R10: A write (`cmd`=2) at edge t stops all read output due at edge t and later.
- R11: `bus_conflict` is 1 for the cycle after the write edge t when any read word due at t or later is unmasked. Only the `dqm` values of edges t-2 and t-1 count, for the words due at t and t+1; later words count as unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low; high forces idle |
| cmd | input | 3 | Command: 0 idle, 1 read, 2 write, 3 burst stop, 4 bank close, 5 mode load |
| bank | input | BANK_W | Bank addressed by read or bank close |
| pre_all | input | 1 | Bank close applies to every bank |
| col | input | COL_W | Start column of a read |
| dqm | input | 1 | Data mask for this cycle |
| mode_bl | input | BL_CODE_W | Burst length code taken on mode load |
| mode_cl | input | CL_CODE_W | Read latency code taken on mode load |
| dout_valid | output | 1 | Read word driven this cycle |
| dout_col | output | COL_W | Column of the driven word, 0 when idle |
| bus_conflict | output | 1 | Write overlapped unmasked read data |

## Verification
A word read at edge t is due at edge t+L+i. A mask raised at edge t acts on edge t+2. A truncation by read, stop or close acts from t+L, while a write acts from t itself. The conflict flag belongs to the write's own edge. For every edge it drives, the bench records the expected word and flag under that edge number, applying these offsets. The monitor samples on the falling edge after each rising edge and compares against the entry for the edge just completed, so a word that comes one cycle early or late is reported as missing or unexpected.

// File: rtl/rdb_pkg.sv
package rdb_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_IDLE  = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_STOP  = 3'd3,
    CMD_CLOSE = 3'd4,
    CMD_MODE  = 3'd5
  } cmd_e;

  // mask true for offset o when that offset falls inside the known mask window
  function automatic logic mask_hit(input logic [7:0] sr, input int lat, input int o);
    if (o < lat) return sr[lat-1-o];
    return 1'b0;
  endfunction
endpackage

// File: rtl/rdb_mode_reg.sv
module rdb_mode_reg #(
  parameter int BL_CODE_W   = 2,
  parameter int CL_CODE_W   = 1,
  parameter int RST_BL_CODE = 2,
  parameter int RST_CL_CODE = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 busy,
  input  logic [BL_CODE_W-1:0] bl_in,
  input  logic [CL_CODE_W-1:0] cl_in,
  output logic [BL_CODE_W-1:0] bl_code,
  output logic [CL_CODE_W-1:0] cl_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bl_code <= BL_CODE_W'(RST_BL_CODE);
      cl_code <= CL_CODE_W'(RST_CL_CODE);
    end else if (load && !busy) begin
      bl_code <= bl_in;
      cl_code <= cl_in;
    end
  end
endmodule

// File: rtl/rdb_burst_gen.sv
module rdb_burst_gen #(
  parameter int COL_W     = 10,
  parameter int BANK_W    = 2,
  parameter int BL_CODE_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 stop,
  input  logic [COL_W-1:0]     start_col,
  input  logic [BANK_W-1:0]    start_bank,
  input  logic [BL_CODE_W-1:0] bl_code,
  output logic                 g_valid,
  output logic                 g_more,
  output logic [COL_W-1:0]     g_col,
  output logic [BANK_W-1:0]    g_bank
);
  localparam int CNT_W = (1 << BL_CODE_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_idx;
  logic [COL_W-1:0] base_col;
  logic [COL_W-1:0] wrap_mask;

  assign last_idx  = CNT_W'((32'd1 << bl_code) - 32'd1);
  assign wrap_mask = COL_W'(last_idx);
  assign g_col     = (base_col & ~wrap_mask) | ((base_col + COL_W'(cnt)) & wrap_mask);
  assign g_more    = g_valid && (cnt != last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      g_valid  <= 1'b0;
      cnt      <= '0;
      base_col <= '0;
      g_bank   <= '0;
    end else if (start) begin
      g_valid  <= 1'b1;
      cnt      <= '0;
      base_col <= start_col;
      g_bank   <= start_bank;
    end else if (stop) begin
      g_valid  <= 1'b0;
    end else if (g_valid) begin
      if (cnt == last_idx) g_valid <= 1'b0;
      else                 cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rdb_out_pipe.sv
module rdb_out_pipe import rdb_pkg::*; #(
  parameter int COL_W     = 10,
  parameter int CL_CODE_W = 1,
  parameter int MIN_CL    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 g_valid,
  input  logic                 g_more,
  input  logic [COL_W-1:0]     g_col,
  input  logic [CL_CODE_W-1:0] cl_code,
  input  logic                 dqm,
  input  logic                 kill,
  output logic                 busy,
  output logic                 out_valid,
  output logic [COL_W-1:0]     out_col,
  output logic                 conflict
);
  localparam int NSTG     = MIN_CL + (1 << CL_CODE_W) - 2;
  localparam int MASK_LAT = 2;

  logic [NSTG-1:0]     dl_v;
  logic [COL_W-1:0]    dl_c [NSTG];
  logic [MASK_LAT-1:0] dqm_sr;
  logic [7:0]          sr_ext;
  int                  tap;
  logic                tap_v;
  logic [COL_W-1:0]    tap_c;
  logic                hazard;

  assign sr_ext = 8'(dqm_sr);
  assign tap    = int'(cl_code) + MIN_CL - 2;

  for (genvar i = 0; i < NSTG; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst || kill) dl_v[i] <= 1'b0;
        else             dl_v[i] <= g_valid;
        dl_c[i] <= g_col;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst || kill) dl_v[i] <= 1'b0;
        else             dl_v[i] <= dl_v[i-1];
        dl_c[i] <= dl_c[i-1];
      end
    end
  end

  always_comb begin
    tap_v  = 1'b0;
    tap_c  = '0;
    busy   = g_valid;
    hazard = 1'b0;
    for (int i = 0; i < NSTG; i++) begin
      if (i == tap) begin
        tap_v = dl_v[i];
        tap_c = dl_c[i];
      end
      if (i <= tap) begin
        busy = busy | dl_v[i];
        if (dl_v[i] && !mask_hit(sr_ext, MASK_LAT, tap - i)) hazard = 1'b1;
      end
    end
    if (g_valid && !mask_hit(sr_ext, MASK_LAT, tap + 1)) hazard = 1'b1;
    if (g_more  && !mask_hit(sr_ext, MASK_LAT, tap + 2)) hazard = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dqm_sr    <= '0;
      out_valid <= 1'b0;
      out_col   <= '0;
      conflict  <= 1'b0;
    end else begin
      dqm_sr    <= {dqm_sr[MASK_LAT-2:0], dqm};
      out_valid <= tap_v && !dqm_sr[MASK_LAT-1] && !kill;
      out_col   <= (tap_v && !dqm_sr[MASK_LAT-1] && !kill) ? tap_c : '0;
      conflict  <= kill && hazard;
    end
  end
endmodule

// File: rtl/rdburst_seq.sv
module rdburst_seq import rdb_pkg::*; #(
  parameter int COL_W       = 10,
  parameter int BANK_W      = 2,
  parameter int BL_CODE_W   = 2,
  parameter int CL_CODE_W   = 1,
  parameter int MIN_CL      = 2,
  parameter int RST_BL_CODE = 2,
  parameter int RST_CL_CODE = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic [CMD_W-1:0]     cmd,
  input  logic [BANK_W-1:0]    bank,
  input  logic                 pre_all,
  input  logic [COL_W-1:0]     col,
  input  logic                 dqm,
  input  logic [BL_CODE_W-1:0] mode_bl,
  input  logic [CL_CODE_W-1:0] mode_cl,
  output logic                 dout_valid,
  output logic [COL_W-1:0]     dout_col,
  output logic                 bus_conflict
);
  cmd_e                 op;
  logic                 do_read, do_write, do_stop, do_close, do_mode;
  logic                 cut;
  logic                 busy;
  logic [BL_CODE_W-1:0] bl_code;
  logic [CL_CODE_W-1:0] cl_code;
  logic                 g_valid, g_more;
  logic [COL_W-1:0]     g_col;
  logic [BANK_W-1:0]    g_bank;

  assign op       = cs_n ? CMD_IDLE : cmd_e'(cmd);
  assign do_read  = (op == CMD_READ);
  assign do_write = (op == CMD_WRITE);
  assign do_stop  = (op == CMD_STOP);
  assign do_close = (op == CMD_CLOSE);
  assign do_mode  = (op == CMD_MODE);
  assign cut      = do_stop || do_write || (do_close && (pre_all || bank == g_bank));

  rdb_mode_reg #(
    .BL_CODE_W(BL_CODE_W), .CL_CODE_W(CL_CODE_W),
    .RST_BL_CODE(RST_BL_CODE), .RST_CL_CODE(RST_CL_CODE)
  ) u_mode (
    .clk(clk), .rst(rst), .load(do_mode), .busy(busy),
    .bl_in(mode_bl), .cl_in(mode_cl), .bl_code(bl_code), .cl_code(cl_code)
  );

  rdb_burst_gen #(.COL_W(COL_W), .BANK_W(BANK_W), .BL_CODE_W(BL_CODE_W)) u_gen (
    .clk(clk), .rst(rst), .start(do_read), .stop(cut),
    .start_col(col), .start_bank(bank), .bl_code(bl_code),
    .g_valid(g_valid), .g_more(g_more), .g_col(g_col), .g_bank(g_bank)
  );

  rdb_out_pipe #(.COL_W(COL_W), .CL_CODE_W(CL_CODE_W), .MIN_CL(MIN_CL)) u_pipe (
    .clk(clk), .rst(rst), .g_valid(g_valid), .g_more(g_more), .g_col(g_col),
    .cl_code(cl_code), .dqm(dqm), .kill(do_write), .busy(busy),
    .out_valid(dout_valid), .out_col(dout_col), .conflict(bus_conflict)
  );
endmodule

// File: rtl/rdb_seq_checker.sv
module rdb_seq_checker #(
  parameter int BL_CODE_W = 2,
  parameter int CL_CODE_W = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cs_n,
  input logic [2:0]           cmd,
  input logic                 dqm,
  input logic                 dout_valid,
  input logic                 bus_conflict,
  input logic                 busy,
  input logic [BL_CODE_W-1:0] bl_code,
  input logic [CL_CODE_W-1:0] cl_code
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= 2'd0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd0) |-> (!dout_valid && !bus_conflict));

  p_mode_hold_r4: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(bl_code) && $stable(cl_code)));

  p_stop_cut_r6: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && cmd == 3'd3 && cl_code == 1'b1) |-> ##4 !dout_valid);

  p_dqm_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $past(dqm, 3)) |-> !dout_valid);

  p_write_kill_r10: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && cmd == 3'd2) |=> !dout_valid);

  p_conflict_src_r11: assert property (@(posedge clk) disable iff (rst)
    bus_conflict |-> $past(!cs_n && cmd == 3'd2));
endmodule

bind rdburst_seq rdb_seq_checker #(.BL_CODE_W(BL_CODE_W), .CL_CODE_W(CL_CODE_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .cmd(cmd), .dqm(dqm),
  .dout_valid(dout_valid), .bus_conflict(bus_conflict),
  .busy(busy), .bl_code(bl_code), .cl_code(cl_code)
);

// File: tb/rdburst_seq_tb_top.sv
module rdburst_seq_tb_top;
  localparam int COL_W = 10;
  localparam int NSLOT = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic [1:0] bank = '0;
  logic pre_all = 1'b0;
  logic [COL_W-1:0] col = '0;
  logic dqm = 1'b0;
  logic [1:0] mode_bl = '0;
  logic mode_cl = 1'b0;
  logic dout_valid;
  logic [COL_W-1:0] dout_col;
  logic bus_conflict;

  always #10 clk = ~clk;

  rdburst_seq dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cmd(cmd), .bank(bank), .pre_all(pre_all),
    .col(col), .dqm(dqm), .mode_bl(mode_bl), .mode_cl(mode_cl),
    .dout_valid(dout_valid), .dout_col(dout_col), .bus_conflict(bus_conflict)
  );

  int ecnt = 0;
  always @(posedge clk) ecnt <= ecnt + 1;

  int n_tests = 0;
  int n_fail  = 0;
  bit mon_on  = 0;
  bit done    = 0;

  // reference state, kept from the requirements alone
  bit               sch_v [NSLOT];
  logic [COL_W-1:0] sch_c [NSLOT];
  bit               msk   [NSLOT];
  bit               cf_exp[NSLOT];
  bit               cf_chk[NSLOT];
  string            tag_at[NSLOT];
  int               m_cl = 3, m_bl = 4, m_bank = 0;

  int               q_edge[$];
  logic [COL_W-1:0] q_col[$];
  string            q_tag[$];

  function automatic void clear_from(int s0);
    for (int s = s0; s < s0 + 20 && s < NSLOT; s++) sch_v[s] = 0;
  endfunction

  task automatic issue(input logic [2:0] c, input int bk, input bit pa, input int cc,
                       input bit dq, input bit csn, input int mbl, input int mcl,
                       input string tag);
    int t;
    bit hit;
    @(negedge clk);
    t = ecnt + 1;
    cs_n = csn; cmd = c; bank = 2'(bk); pre_all = pa; col = COL_W'(cc);
    dqm = dq; mode_bl = 2'(mbl); mode_cl = mcl[0];
    tag_at[t] = tag;
    if (dq) msk[t+2] = 1;
    if (!csn) begin
      case (c)
        3'd1: begin
          clear_from(t + m_cl);
          for (int i = 0; i < m_bl; i++) begin
            sch_v[t+m_cl+i] = 1;
            sch_c[t+m_cl+i] = COL_W'((cc & ~(m_bl-1)) | ((cc + i) & (m_bl-1)));
          end
          m_bank = bk;
        end
        3'd2: begin
          hit = 0;
          for (int s = t; s < t + 20; s++)
            if (sch_v[s] && !(s <= t + 1 && msk[s])) hit = 1;
          cf_exp[t] = hit; cf_chk[t] = 1;
          clear_from(t);
        end
        3'd3: clear_from(t + m_cl);
        3'd4: if (pa || bk == m_bank) clear_from(t + m_cl);
        3'd5: begin
          hit = 0;
          for (int s = t; s < t + 20; s++) if (sch_v[s]) hit = 1;
          if (!hit) begin m_bl = 1 << mbl; m_cl = 2 + mcl; end
        end
        default: ;
      endcase
    end
    if (sch_v[t] && !msk[t]) begin
      q_edge.push_back(t); q_col.push_back(sch_c[t]); q_tag.push_back(tag_at[t]);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) issue(3'd0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic rd(input int bk, input int cc, input string tag);
    issue(3'd1, bk, 0, cc, 0, 0, 0, 0, tag);
  endtask
  task automatic lm(input int bl, input int cl, input string tag);
    issue(3'd5, 0, 0, 0, 0, 0, bl, cl, tag);
  endtask

  // monitor: compares each finished edge against the queue head
  always @(negedge clk) begin
    int k;
    k = ecnt;
    if (mon_on && k < NSLOT) begin
      if (q_edge.size() > 0 && q_edge[0] == k) begin
        n_tests++;
        if (!dout_valid || dout_col !== q_col[0]) begin
          n_fail++;
          $display("FAIL %s edge %0d: valid=%0b col=%0d expected valid=1 col=%0d",
                   q_tag[0], k, dout_valid, dout_col, q_col[0]);
        end
        void'(q_edge.pop_front()); void'(q_col.pop_front()); void'(q_tag.pop_front());
      end else if (dout_valid || tag_at[k] != "") begin
        n_tests++;
        if (dout_valid) begin
          n_fail++;
          $display("FAIL %s edge %0d: valid=1 col=%0d expected valid=0",
                   tag_at[k], k, dout_col);
        end
      end
      if (cf_chk[k] || bus_conflict) begin
        n_tests++;
        if (bus_conflict !== cf_exp[k]) begin
          n_fail++;
          $display("FAIL %s edge %0d: bus_conflict=%0b expected %0b",
                   tag_at[k], k, bus_conflict, cf_exp[k]);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: run did not end, actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (dout_valid !== 1'b0 || bus_conflict !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: valid=%0b conflict=%0b expected 0 0", dout_valid, bus_conflict);
    end
    rst = 1'b0;
    mon_on = 1;
    idle(2, "R1");
    // R1 default mode, R2/R3 latency 3 length 4 from column 5
    rd(0, 5, "R1"); idle(8, "R3");
    // R3/R4 length 8 from column 13
    lm(3, 1, "R4"); idle(1, "R4"); rd(1, 13, "R3"); idle(12, "R3");
    // R2 latency 2, wrap at top of column space
    lm(3, 0, "R2"); rd(0, 1022, "R2"); idle(11, "R2");
    // R4 length 1 and 2
    lm(0, 0, "R4"); rd(0, 9, "R4"); idle(4, "R4");
    lm(1, 0, "R4"); rd(0, 7, "R3"); idle(5, "R3");
    // R5 read interrupts read
    lm(2, 1, "R5"); rd(0, 0, "R5"); idle(1, "R5"); rd(2, 20, "R5"); idle(8, "R5");
    // R6 stop, same-bank close, close all
    rd(1, 4, "R6"); idle(1, "R6"); issue(3'd3, 0, 0, 0, 0, 0, 0, 0, "R6"); idle(6, "R6");
    rd(1, 4, "R6"); idle(1, "R6"); issue(3'd4, 1, 0, 0, 0, 0, 0, 0, "R6"); idle(6, "R6");
    rd(1, 4, "R6"); idle(1, "R6"); issue(3'd4, 3, 1, 0, 0, 0, 0, 0, "R6"); idle(6, "R6");
    // R7 close of another bank
    rd(1, 4, "R7"); idle(1, "R7"); issue(3'd4, 2, 0, 0, 0, 0, 0, 0, "R7"); idle(7, "R7");
    // R8 mask first and third words
    rd(0, 8, "R8");
    issue(3'd0, 0, 0, 0, 1, 0, 0, 0, "R8");
    issue(3'd0, 0, 0, 0, 0, 0, 0, 0, "R8");
    issue(3'd0, 0, 0, 0, 1, 0, 0, 0, "R8");
    idle(6, "R8");
    // R9 deselected read, deselected stop
    issue(3'd1, 0, 0, 3, 0, 1, 0, 0, "R9"); idle(7, "R9");
    rd(0, 0, "R9"); idle(1, "R9"); issue(3'd3, 0, 0, 0, 0, 1, 0, 0, "R9"); idle(7, "R9");
    // R10/R11 write mid-burst, unmasked
    rd(0, 0, "R10"); idle(3, "R10"); issue(3'd2, 0, 0, 0, 0, 0, 0, 0, "R10"); idle(6, "R10");
    // R11 write after masked tail, length 2 latency 2
    lm(1, 0, "R11"); rd(0, 6, "R11");
    issue(3'd0, 0, 0, 0, 1, 0, 0, 0, "R11");
    issue(3'd0, 0, 0, 0, 1, 0, 0, 0, "R11");
    issue(3'd2, 0, 0, 0, 0, 0, 0, 0, "R11"); idle(5, "R11");
    issue(3'd2, 0, 0, 0, 0, 0, 0, 0, "R11"); idle(3, "R11");
    // R4 mode load while busy is ignored
    lm(2, 1, "R4"); rd(0, 0, "R4"); lm(0, 0, "R4"); idle(8, "R4");
    rd(0, 2, "R4"); idle(8, "R4");
    if (q_edge.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL %s: %0d words never seen, expected 0", q_tag[0], q_edge.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule